// File: doc/BRIEF.md
# Ethernet Transmit Status and Enable Register Block

This block sits beside the transmit engine of a 10 Mb/s Ethernet MAC. It owns the transmit-enable control and the transmit status word. The transmit engine reports what happens during each frame through single-cycle event pulses: start and end of a frame, collisions, deferral, underrun, and missing carrier at the end of the preamble. The block keeps these events as status bits. A small control write from the host sets the enable, turns carrier monitoring on or off and gates the link-change interrupt. A host read of the statistics counters clears the counter-rollover flag.

Two error events, underrun and lost carrier, switch the transmitter off by themselves. Their flags stay set until the host turns the transmitter on again. When the host turns the transmitter off, the frame already in progress runs to completion. At every frame end the block puts a 16-bit snapshot of the status word on a one-cycle strobe, so that the packet-memory write-back path can store it as the first word of that packet. A change of the link-integrity level raises a one-cycle interrupt pulse when the host has allowed it.

Top module: `eth_tx_stat_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `tx_enable`, `tx_active`, `wb_valid` and `irq_link` are 0 and `status_word` is all zero.
- R2: A control write (`host_ctrl_we`) loads wdata bit 0 as transmit enable, bit 1 as carrier-monitor enable and bit 2 as link-event enable. The new enable appears on `tx_enable` and on status bit 11 in the next cycle.
- R3: `tx_active` is high while the enable is set, or from the cycle after a frame start until the cycle after that frame's done pulse. Clearing the enable mid-frame therefore lets the frame finish.
- R4: An underrun pulse sets status bit 8 and clears the enable in the next cycle. Bit 8 is cleared by a control write that sets the enable. If that write falls in the same cycle as an underrun, the underrun wins: the enable goes to 0 and bit 8 goes to 1.
- R5: A no-carrier pulse while carrier monitoring is enabled sets status bit 7 and clears the enable. The pulse has no effect while monitoring is off. Bit 7 is cleared by a control write that sets the enable, and the automatic clear again takes priority.
- R6: Status bit 6 is set once a frame receives more than DEFER_LIMIT deferral byte-time ticks (default 3036). A frame start restarts the count. The bit is cleared in the cycle after each frame done.
- R7: A counter-at-maximum pulse sets status bit 9. A counter read clears it. When both arrive in the same cycle, the bit ends up set.
- R8: Status bits 0 (success), 1 (single collision), 2 (multiple collisions), 3 (16 collisions), 4 (late collision) and 5 (deferred) are cleared by a frame start and set by their pulses. A pulse in the same cycle as the start still sets its bit.
- R9: Status bit 10 follows `link_ok_in` one cycle later. `irq_link` pulses for one cycle together with each change of bit 10, but only while the link-event enable is set.
- R10: One cycle after a frame done pulse, `wb_valid` is high for exactly one cycle. `wb_word` then equals that cycle's `status_word`, except that bit 6 holds the deferral flag as it stood before the end-of-frame clear.
- R11: Status bits 15 to 12 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_ctrl_we | input | 1 | Control write strobe |
| host_ctrl_wdata | input | 3 | {link-event enable, carrier-monitor enable, transmit enable} |
| host_cnt_rd | input | 1 | Host read of the statistics counters |
| eng_frame_start | input | 1 | Frame start pulse |
| eng_frame_done | input | 1 | Frame completion pulse |
| eng_tx_ok | input | 1 | Frame sent successfully |
| eng_underrun | input | 1 | Transmit underrun pulse |
| eng_defer_tick | input | 1 | One byte time spent deferring |
| eng_deferred | input | 1 | Frame was deferred at least once |
| eng_no_carrier | input | 1 | Carrier absent at end of preamble |
| eng_col_single | input | 1 | Exactly one collision |
| eng_col_multi | input | 1 | More than one collision |
| eng_col_16 | input | 1 | Sixteen collisions, frame abandoned |
| eng_col_late | input | 1 | Late collision |
| link_ok_in | input | 1 | Link-integrity level |
| cnt_at_max | input | 1 | A statistics counter reached 15 |
| tx_enable | output | 1 | Enable to the transmit engine |
| tx_active | output | 1 | Transmitter running or draining a frame |
| status_word | output | 16 | Live status word |
| wb_valid | output | 1 | Snapshot strobe |
| wb_word | output | 16 | Status snapshot for packet memory |
| irq_link | output | 1 | Link-change interrupt pulse |

## Verification
Two functions can land in the same cycle on the enable. One is the host write that sets it; the other is the automatic clear caused by underrun or lost carrier. The bench drives both in one cycle and expects the enable low with the error flag set, on the reference model's priority. It also collides a counter-maximum pulse with a counter read, a collision pulse with a frame start, and deferral overflow with frame completion, where the flag must reach the snapshot but not survive in the live word. All outputs are compared against the behavioural model on every clock.

// File: rtl/txs_pkg.sv
// Package txs_pkg
// Shared bit positions and widths for the transmit status block.
// Assumes a 16-bit status word; unused upper bits read as zero.
package txs_pkg;
    localparam int STAT_W    = 16;
    localparam int CTRL_W    = 3;
    localparam int FRM_BITS  = 6;

    // status word bit positions
    localparam int B_SUCC = 0;
    localparam int B_SCOL = 1;
    localparam int B_MCOL = 2;
    localparam int B_C16  = 3;
    localparam int B_LATE = 4;
    localparam int B_DEFR = 5;
    localparam int B_EXCD = 6;
    localparam int B_LOST = 7;
    localparam int B_UNRN = 8;
    localparam int B_ROLL = 9;
    localparam int B_LINK = 10;
    localparam int B_TXEN = 11;

    // control write data bit positions
    localparam int CW_TXEN = 0;
    localparam int CW_MON  = 1;
    localparam int CW_LIE  = 2;

    // Assemble a status word; frame bits occupy positions 0..FRM_BITS-1.
    function automatic logic [STAT_W-1:0] pack_status(
        input logic [FRM_BITS-1:0] frm,
        input logic exc, input logic lost, input logic unrn,
        input logic roll, input logic link, input logic txen);
        logic [STAT_W-1:0] w;
        w = '0;
        w[FRM_BITS-1:0] = frm;
        w[B_EXCD] = exc;
        w[B_LOST] = lost;
        w[B_UNRN] = unrn;
        w[B_ROLL] = roll;
        w[B_LINK] = link;
        w[B_TXEN] = txen;
        return w;
    endfunction
endpackage

// File: rtl/txs_enable_ctl.sv
// Module txs_enable_ctl
// Holds transmit enable, carrier-monitor enable, the underrun and
// lost-carrier error flags, and the in-frame tracker used to drain a
// frame after the enable is dropped.
// Assumes engine pulses are one cycle wide and frame start/done bracket
// each frame. Automatic clears beat a simultaneous host set.
module txs_enable_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_txen,
    input  logic wr_mon,
    input  logic underrun,
    input  logic no_carrier,
    input  logic frame_start,
    input  logic frame_done,
    output logic txen_q,
    output logic txen_nx,
    output logic unrn_q,
    output logic unrn_nx,
    output logic lost_q,
    output logic lost_nx,
    output logic active
);
    logic mon_q;
    logic inframe_q;
    logic carrier_err;
    logic auto_clr;
    logic host_set;

    // decode error causes and host set request
    always_comb begin
        carrier_err = no_carrier & mon_q;
        auto_clr    = underrun | carrier_err;
        host_set    = wr_en & wr_txen;
    end

    // next-state of enable and error flags
    always_comb begin
        if (auto_clr)   txen_nx = 1'b0;
        else if (wr_en) txen_nx = wr_txen;
        else            txen_nx = txen_q;

        if (underrun)      unrn_nx = 1'b1;
        else if (host_set) unrn_nx = 1'b0;
        else               unrn_nx = unrn_q;

        if (carrier_err)   lost_nx = 1'b1;
        else if (host_set) lost_nx = 1'b0;
        else               lost_nx = lost_q;
    end

    // register enable, flags, monitor enable and frame tracker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txen_q    <= 1'b0;
            unrn_q    <= 1'b0;
            lost_q    <= 1'b0;
            mon_q     <= 1'b0;
            inframe_q <= 1'b0;
        end else begin
            txen_q    <= txen_nx;
            unrn_q    <= unrn_nx;
            lost_q    <= lost_nx;
            if (wr_en) mon_q <= wr_mon;
            inframe_q <= frame_start | (inframe_q & ~frame_done);
        end
    end

    // transmitter stays active while enabled or draining a frame
    always_comb active = txen_q | inframe_q;

    p_autoclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> (!txen_q && unrn_q));
    p_lostcar_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (no_carrier && mon_q) |=> (!txen_q && lost_q));
    p_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inframe_q && !frame_done) |=> active);
    p_hostset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_txen && !underrun && !(no_carrier && mon_q)) |=> txen_q);
endmodule

// File: rtl/txs_frame_stat.sv
// Module txs_frame_stat
// Keeps the per-frame event bits, the deferral byte-time counter with
// its excessive-deferral flag, and the counter-rollover flag.
// Assumes one tick per deferred byte time; the counter saturates just
// above the limit so its width stays small.
module txs_frame_stat #(
    parameter int FRM_BITS    = 6,
    parameter int DEFER_LIMIT = 3036
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                frame_done,
    input  logic [FRM_BITS-1:0] ev,
    input  logic                defer_tick,
    input  logic                cnt_at_max,
    input  logic                cnt_rd,
    output logic [FRM_BITS-1:0] frm_q,
    output logic [FRM_BITS-1:0] frm_nx,
    output logic                exc_q,
    output logic                exc_raw,
    output logic                roll_q,
    output logic                roll_nx
);
    localparam int DSAT  = DEFER_LIMIT + 1;
    localparam int DCNTW = $clog2(DSAT + 1);
    localparam logic [DCNTW-1:0] DLIM_V = DCNTW'(DEFER_LIMIT);
    localparam logic [DCNTW-1:0] DSAT_V = DCNTW'(DSAT);

    logic [DCNTW-1:0] dcnt_q;
    logic [DCNTW-1:0] dcnt_nx;
    logic             exc_set;

    // one sticky bit per frame event, cleared at frame start
    for (genvar i = 0; i < FRM_BITS; i++) begin : g_frm
        always_comb frm_nx[i] = (frame_start ? 1'b0 : frm_q[i]) | ev[i];

        // hold the bit until the next frame start
        always_ff @(posedge clk) begin
            if (!rst_n) frm_q[i] <= 1'b0;
            else        frm_q[i] <= frm_nx[i];
        end
    end

    // deferral count, restarted per frame, saturating above the limit
    always_comb begin
        exc_set = defer_tick & ~frame_start & (dcnt_q == DLIM_V);
        if (frame_start)                       dcnt_nx = '0;
        else if (defer_tick && dcnt_q != DSAT_V) dcnt_nx = dcnt_q + 1'b1;
        else                                   dcnt_nx = dcnt_q;
        exc_raw = frame_start ? 1'b0 : (exc_q | exc_set);
        roll_nx = cnt_at_max | (roll_q & ~cnt_rd);
    end

    // register counter and flags; frame done clears excessive deferral
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt_q <= '0;
            exc_q  <= 1'b0;
            roll_q <= 1'b0;
        end else begin
            dcnt_q <= dcnt_nx;
            exc_q  <= frame_done ? 1'b0 : exc_raw;
            roll_q <= roll_nx;
        end
    end

    p_roll_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_at_max |=> roll_q);
    p_exc_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !exc_q);
    p_frm_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && ev == '0) |=> (frm_q == '0));
endmodule

// File: rtl/txs_link_mon.sv
// Module txs_link_mon
// Samples the link-integrity level and raises a one-cycle interrupt on
// each change while the link-event enable is set.
// Assumes link_ok_in is already synchronous to clk.
module txs_link_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_lie,
    input  logic link_in,
    output logic link_q,
    output logic irq_q
);
    logic lie_q;

    // sample link, hold enable, flag gated changes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q <= 1'b0;
            lie_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            link_q <= link_in;
            if (wr_en) lie_q <= wr_lie;
            irq_q  <= lie_q & (link_in ^ link_q);
        end
    end

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lie_q |=> !irq_q);
    p_irq_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (link_q != $past(link_q)));
endmodule

// File: rtl/eth_tx_stat_ctrl.sv
// Module eth_tx_stat_ctrl
// Top of the transmit status and enable block: assembles the live status
// word and the per-frame snapshot for packet-memory write-back.
// Assumes all inputs are synchronous and pulses last one cycle.
module eth_tx_stat_ctrl #(
    parameter int DEFER_LIMIT = 3036
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_ctrl_we,
    input  logic [2:0]  host_ctrl_wdata,
    input  logic        host_cnt_rd,
    input  logic        eng_frame_start,
    input  logic        eng_frame_done,
    input  logic        eng_tx_ok,
    input  logic        eng_underrun,
    input  logic        eng_defer_tick,
    input  logic        eng_deferred,
    input  logic        eng_no_carrier,
    input  logic        eng_col_single,
    input  logic        eng_col_multi,
    input  logic        eng_col_16,
    input  logic        eng_col_late,
    input  logic        link_ok_in,
    input  logic        cnt_at_max,
    output logic        tx_enable,
    output logic        tx_active,
    output logic [15:0] status_word,
    output logic        wb_valid,
    output logic [15:0] wb_word,
    output logic        irq_link
);
    import txs_pkg::*;

    logic txen_q, txen_nx, unrn_q, unrn_nx, lost_q, lost_nx;
    logic [FRM_BITS-1:0] ev, frm_q, frm_nx;
    logic exc_q, exc_raw, roll_q, roll_nx, link_q;
    logic              wbv_q;
    logic [STAT_W-1:0] wbw_q;

    // gather engine events in status-bit order
    always_comb begin
        ev         = '0;
        ev[B_SUCC] = eng_tx_ok;
        ev[B_SCOL] = eng_col_single;
        ev[B_MCOL] = eng_col_multi;
        ev[B_C16]  = eng_col_16;
        ev[B_LATE] = eng_col_late;
        ev[B_DEFR] = eng_deferred;
    end

    txs_enable_ctl u_en (
        .clk(clk), .rst_n(rst_n),
        .wr_en(host_ctrl_we),
        .wr_txen(host_ctrl_wdata[CW_TXEN]),
        .wr_mon(host_ctrl_wdata[CW_MON]),
        .underrun(eng_underrun), .no_carrier(eng_no_carrier),
        .frame_start(eng_frame_start), .frame_done(eng_frame_done),
        .txen_q(txen_q), .txen_nx(txen_nx),
        .unrn_q(unrn_q), .unrn_nx(unrn_nx),
        .lost_q(lost_q), .lost_nx(lost_nx),
        .active(tx_active)
    );

    txs_frame_stat #(.FRM_BITS(FRM_BITS), .DEFER_LIMIT(DEFER_LIMIT)) u_fs (
        .clk(clk), .rst_n(rst_n),
        .frame_start(eng_frame_start), .frame_done(eng_frame_done),
        .ev(ev), .defer_tick(eng_defer_tick),
        .cnt_at_max(cnt_at_max), .cnt_rd(host_cnt_rd),
        .frm_q(frm_q), .frm_nx(frm_nx),
        .exc_q(exc_q), .exc_raw(exc_raw),
        .roll_q(roll_q), .roll_nx(roll_nx)
    );

    txs_link_mon u_lk (
        .clk(clk), .rst_n(rst_n),
        .wr_en(host_ctrl_we), .wr_lie(host_ctrl_wdata[CW_LIE]),
        .link_in(link_ok_in),
        .link_q(link_q), .irq_q(irq_link)
    );

    // capture the completed frame's status for write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbv_q <= 1'b0;
            wbw_q <= '0;
        end else begin
            wbv_q <= eng_frame_done;
            if (eng_frame_done)
                wbw_q <= pack_status(frm_nx, exc_raw, lost_nx, unrn_nx,
                                     roll_nx, link_ok_in, txen_nx);
        end
    end

    // drive outputs
    always_comb begin
        tx_enable   = txen_q;
        status_word = pack_status(frm_q, exc_q, lost_q, unrn_q,
                                  roll_q, link_q, txen_q);
        wb_valid    = wbv_q;
        wb_word     = wbw_q;
    end

    p_wb_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(eng_frame_done));
    p_wb_txen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_word[B_TXEN] == tx_enable));
endmodule

// File: tb/tb_eth_tx_stat_ctrl.sv
module tb_eth_tx_stat_ctrl;
    localparam int LIM = 3036;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we = 0, rd = 0, fs = 0, fd = 0, ok = 0, ur = 0, dt = 0, df = 0;
    logic nc = 0, c1 = 0, cm = 0, c16 = 0, cl = 0, lk = 0, cmax = 0;
    logic [2:0] wd = '0;
    logic tx_enable, tx_active, wb_valid, irq_link;
    logic [15:0] status_word, wb_word;

    int checks = 0, errors = 0, cyc = 0;
    bit started = 0, finished = 0;

    always #4 clk = ~clk;

    eth_tx_stat_ctrl #(.DEFER_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .host_ctrl_we(we), .host_ctrl_wdata(wd),
        .host_cnt_rd(rd), .eng_frame_start(fs), .eng_frame_done(fd),
        .eng_tx_ok(ok), .eng_underrun(ur), .eng_defer_tick(dt),
        .eng_deferred(df), .eng_no_carrier(nc), .eng_col_single(c1),
        .eng_col_multi(cm), .eng_col_16(c16), .eng_col_late(cl),
        .link_ok_in(lk), .cnt_at_max(cmax), .tx_enable(tx_enable),
        .tx_active(tx_active), .status_word(status_word), .wb_valid(wb_valid),
        .wb_word(wb_word), .irq_link(irq_link)
    );

    // behavioural reference state
    bit m_en, m_un, m_lc, m_mon, m_ie, m_busy, m_exc, m_rol, m_lnk, m_irq, m_wbv;
    bit [5:0] m_fr;
    int m_dcnt;
    bit [15:0] m_wbw;

    function automatic bit [15:0] mk(bit [5:0] f, bit x, bit l, bit u,
                                      bit r, bit k, bit e);
        return {4'h0, e, k, r, u, l, x, f};
    endfunction

    always @(posedge clk) begin : model
        bit n_en, n_un, n_lc, n_exc, n_rol;
        bit [5:0] n_fr;
        started = 1;
        if (!rst_n) begin
            m_en = 0; m_un = 0; m_lc = 0; m_mon = 0; m_ie = 0; m_busy = 0;
            m_exc = 0; m_rol = 0; m_lnk = 0; m_irq = 0; m_wbv = 0;
            m_fr = 0; m_dcnt = 0; m_wbw = 0;
        end else begin
            n_en = m_en; n_un = m_un; n_lc = m_lc;
            if (we) begin
                n_en = wd[0];
                if (wd[0]) begin n_un = 0; n_lc = 0; end
            end
            if (ur) begin n_en = 0; n_un = 1; end
            if (nc && m_mon) begin n_en = 0; n_lc = 1; end
            n_fr = fs ? 6'd0 : m_fr;
            n_fr = n_fr | {df, cl, c16, cm, c1, ok};
            n_exc = m_exc;
            if (fs) begin n_exc = 0; m_dcnt = 0; end
            else if (dt) begin
                m_dcnt++;
                if (m_dcnt > LIM) n_exc = 1;
            end
            n_rol = cmax ? 1'b1 : (rd ? 1'b0 : m_rol);
            m_irq = m_ie && (lk != m_lnk);
            m_wbv = fd;
            if (fd) m_wbw = mk(n_fr, n_exc, n_lc, n_un, n_rol, lk, n_en);
            if (we) begin m_mon = wd[1]; m_ie = wd[2]; end
            m_busy = fs ? 1'b1 : (fd ? 1'b0 : m_busy);
            m_en = n_en; m_un = n_un; m_lc = n_lc; m_fr = n_fr;
            m_exc = fd ? 1'b0 : n_exc; m_rol = n_rol; m_lnk = lk;
        end
    end

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R2 tx_enable", {15'd0, tx_enable}, {15'd0, m_en});
            chk("R3 tx_active", {15'd0, tx_active}, {15'd0, m_en | m_busy});
            chk("R8 frame bits", {10'd0, status_word[5:0]}, {10'd0, m_fr});
            chk("R6 exc deferral", {15'd0, status_word[6]}, {15'd0, m_exc});
            chk("R5 lost carrier", {15'd0, status_word[7]}, {15'd0, m_lc});
            chk("R4 underrun", {15'd0, status_word[8]}, {15'd0, m_un});
            chk("R7 rollover", {15'd0, status_word[9]}, {15'd0, m_rol});
            chk("R9 link bit", {15'd0, status_word[10]}, {15'd0, m_lnk});
            chk("R2 enable bit", {15'd0, status_word[11]}, {15'd0, m_en});
            chk("R11 reserved", {12'd0, status_word[15:12]}, 16'd0);
            chk("R9 irq_link", {15'd0, irq_link}, {15'd0, m_irq});
            chk("R10 wb_valid", {15'd0, wb_valid}, {15'd0, m_wbv});
            if (wb_valid) chk("R10 wb_word", wb_word, m_wbw);
        end
    end

    task automatic summary();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            we = 0; rd = 0; fs = 0; fd = 0; ok = 0; ur = 0; dt = 0; df = 0;
            nc = 0; c1 = 0; cm = 0; c16 = 0; cl = 0; cmax = 0;
        end
    endtask

    task automatic wr(logic [2:0] v);
        we = 1; wd = v; step();
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step();
        // R1 reset state seen directly
        chk("R1 status", status_word, 16'd0);
        chk("R1 outputs", {12'd0, tx_enable, tx_active, wb_valid, irq_link}, 16'd0);
        lk = 1; step(2);                       // R9 change, interrupt gated off
        wr(3'b111); step();
        lk = 0; step(2);                       // R9 interrupt
        lk = 1; step(2);
        fs = 1; step(); c1 = 1; step(); df = 1; step(); fd = 1; ok = 1; step(2);
        fs = 1; step(); cm = 1; step(); c16 = 1; cl = 1; step(); fd = 1; step(2);
        fs = 1; c1 = 1; step(2);               // R8 pulse on start cycle
        wr(3'b110); step(3); fd = 1; ok = 1; step(2);   // R3 drain
        wr(3'b111); fs = 1; step(); ur = 1; step(2); fd = 1; step(2);
        wr(3'b111); step();                    // R4 host clear
        we = 1; wd = 3'b111; ur = 1; step(2);  // R4 same-cycle priority
        wr(3'b111); nc = 1; step(2);           // R5 set
        wr(3'b111); step();
        we = 1; wd = 3'b111; nc = 1; step(2);  // R5 priority
        wr(3'b101); nc = 1; step(2);           // R5 ignored, monitor off
        wr(3'b111);
        fs = 1; step();
        for (int i = 0; i < LIM; i++) begin dt = 1; step(); end
        fd = 1; ok = 1; step(2);               // R6 exactly at limit
        fs = 1; step();
        for (int i = 0; i < LIM + 1; i++) begin dt = 1; step(); end
        step(); fd = 1; ok = 1; step(3);       // R6 over limit, R10 snapshot
        cmax = 1; step(2); rd = 1; step(2);    // R7
        cmax = 1; rd = 1; step(2); rd = 1; step(2);
        wr(3'b011); lk = 0; step(2); lk = 1; step(2);   // R9 gated
        step(4);
        summary();
    end
endmodule